// File: doc/BRIEF.md
# Bit-timing recovery loop

This block rebuilds a receive bit clock from a demodulated serial stream. The stream is already sampled by a local clock that runs at 64 times the bit rate. A free-running bit-phase counter sets the phase of the rebuilt clock. Each time the incoming data changes level, the block reads the counter as a signed phase error and nudges the counter toward the ideal edge position. Bits are sampled at mid-bit and presented on the falling edge of the rebuilt clock.

Two static controls set how the loop behaves. `fast_en` lets the loop take a large correction step while the error exceeds 22.5 degrees, which is 4 counts. `slow_acq` picks the acquisition speed. A lock flag reports when the loop has settled. The flag is set after a run of transitions with small error, and it is cleared after a run of transitions with large error.

Top module: `bitclk_dpll`

## Requirements
- R1: While `rst` is high at a clock edge, the counter goes to 0, so `rclk` is 1 after the edge. `rdata` and `locked` are 0 after that edge.
- R2: `rclk` is 1 while the counter holds 0..31 and 0 while it holds 32..63. Between corrections the counter steps by +1 on every clock, so with no data transitions `rclk` has a period of 64 clocks.
- R3: `din` passes through two register stages. A transition is a difference between those two stages. `rdata` changes only at the edge where `rclk` falls, and it takes the first-stage value at that edge.
- R4: At each transition the counter value is read as a signed error: 0..31 is positive and 32..63 means value minus 64. A positive error retards the counter by the step, a negative error advances it, and zero leaves it alone. The step is never larger than the error magnitude.
- R5: With `fast_en`=1 and an error magnitude above 4, the step is 4 when `slow_acq`=0 and 1 when `slow_acq`=1.
- R6: With an error magnitude of 4 or less, or with `fast_en`=0, the step is 1 (clamped as in R4). This takes effect at the very transition where the condition first holds.
- R7: `locked` is set once 8 transitions in a row have an error magnitude of at most 1. It is cleared once 4 transitions in a row have a magnitude above 4. A transition with a magnitude of 2..4 breaks both runs.
- R8: With `fast_en`=1 and `slow_acq`=0, an alternating 1/0 pattern starting from any phase sets `locked` within 18 bit periods. With `fast_en`=0 the same pattern from half a bit off has not locked by then.
- R9: With `slow_acq`=1, an alternating pattern sets `locked` within 50 bit periods.
- R10: A stretch with no transitions changes neither the counter's advance nor `locked`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 64x the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Demodulated serial data |
| fast_en | input | 1 | Allow the large correction step |
| slow_acq | input | 1 | 1 = slow acquisition (large step is 1) |
| rclk | output | 1 | Rebuilt bit timing clock |
| rdata | output | 1 | Retimed data, changes when rclk falls |
| locked | output | 1 | Loop settled indicator |

## Verification
A level change on `din` reaches the transition detector two edges later. The counter correction shows on `rclk` from the edge that detects the transition. `locked` and `rdata` move on that same edge. The bench's reference model steps on the same rising edge from the inputs it sees there. Every output is compared against the model at the following falling edge, so all three latencies are checked on every cycle. The lock-time checks for R8 and R9 are taken one full bit period after the last counted transition. That margin covers the two-stage input delay with room to spare.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  // quality of one measured transition, as seen by the lock monitor
  typedef enum logic [1:0] {
    GR_MID  = 2'd0,
    GR_NEAR = 2'd1,
    GR_FAR  = 2'd2
  } grade_t;
endpackage

// File: rtl/dpll_edge_det.sv
module dpll_edge_det #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic trn,
  output logic dly
);
  logic [SYNC_N-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[SYNC_N-2:0], din};
  end

  assign trn = stg[SYNC_N-1] ^ stg[SYNC_N-2];
  assign dly = stg[SYNC_N-2];
endmodule

// File: rtl/dpll_phase_err.sv
module dpll_phase_err
  import dpll_pkg::*;
#(
  parameter int PH_W     = 6,
  parameter int BIG_STEP = 4,
  parameter int NEAR_TOL = 1
) (
  input  logic [PH_W-1:0] ph,
  input  logic            fast_en,
  input  logic            slow_acq,
  output logic [PH_W-1:0] step,
  output logic            adv,
  output grade_t          grade
);
  localparam int FAR_LIM = (1 << PH_W) / 16;

  logic signed [PH_W-1:0] err;
  logic        [PH_W-1:0] mag;
  logic        [PH_W-1:0] base;
  logic                   far;

  always_comb begin
    err  = $signed(ph);
    adv  = err[PH_W-1];
    mag  = adv ? PH_W'(-err) : PH_W'(err);
    far  = mag > PH_W'(FAR_LIM);
    base = (fast_en && far && !slow_acq) ? PH_W'(BIG_STEP) : PH_W'(1);
    step = (mag < base) ? mag : base;
    if (mag <= PH_W'(NEAR_TOL)) grade = GR_NEAR;
    else if (far)               grade = GR_FAR;
    else                        grade = GR_MID;
  end
endmodule

// File: rtl/dpll_lock_mon.sv
module dpll_lock_mon
  import dpll_pkg::*;
#(
  parameter int GOOD_RUN = 8,
  parameter int BAD_RUN  = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   trn,
  input  grade_t grade,
  output logic   locked
);
  localparam int GW = $clog2(GOOD_RUN + 1);
  localparam int BW = $clog2(BAD_RUN + 1);

  logic [GW-1:0] good;
  logic [BW-1:0] bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      good   <= '0;
      bad    <= '0;
      locked <= 1'b0;
    end else if (trn) begin
      case (grade)
        GR_NEAR: begin
          bad <= '0;
          if (good != GW'(GOOD_RUN)) good <= good + GW'(1);
          if (good >= GW'(GOOD_RUN - 1)) locked <= 1'b1;
        end
        GR_FAR: begin
          good <= '0;
          if (bad != BW'(BAD_RUN)) bad <= bad + BW'(1);
          if (bad >= BW'(BAD_RUN - 1)) locked <= 1'b0;
        end
        default: begin
          good <= '0;
          bad  <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/bitclk_dpll.sv
module bitclk_dpll
  import dpll_pkg::*;
#(
  parameter int PH_W     = 6,
  parameter int BIG_STEP = 4,
  parameter int NEAR_TOL = 1,
  parameter int GOOD_RUN = 8,
  parameter int BAD_RUN  = 4,
  parameter int SYNC_N   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic fast_en,
  input  logic slow_acq,
  output logic rclk,
  output logic rdata,
  output logic locked
);
  logic            trn;
  logic            dly;
  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] ph_nxt;
  logic [PH_W-1:0] step;
  logic            adv;
  grade_t          grade;

  dpll_edge_det #(.SYNC_N(SYNC_N)) u_edge (
    .clk(clk), .rst(rst), .din(din), .trn(trn), .dly(dly)
  );

  dpll_phase_err #(.PH_W(PH_W), .BIG_STEP(BIG_STEP), .NEAR_TOL(NEAR_TOL)) u_err (
    .ph(ph), .fast_en(fast_en), .slow_acq(slow_acq),
    .step(step), .adv(adv), .grade(grade)
  );

  dpll_lock_mon #(.GOOD_RUN(GOOD_RUN), .BAD_RUN(BAD_RUN)) u_lock (
    .clk(clk), .rst(rst), .trn(trn), .grade(grade), .locked(locked)
  );

  always_comb begin
    ph_nxt = ph + PH_W'(1);
    if (trn) ph_nxt = adv ? (ph_nxt + step) : (ph_nxt - step);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= '0;
      rdata <= 1'b0;
    end else begin
      ph <= ph_nxt;
      if (!ph[PH_W-1] && ph_nxt[PH_W-1]) rdata <= dly;
    end
  end

  assign rclk = ~ph[PH_W-1];
endmodule

// File: rtl/dpll_chk.sv
module dpll_chk #(
  parameter int PH_W     = 6,
  parameter int BIG_STEP = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            fast_en,
  input logic            rclk,
  input logic            rdata,
  input logic            locked,
  input logic            trn,
  input logic [PH_W-1:0] ph
);
  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rclk && !rdata && !locked));

  assert_free_run_R2: assert property (@(posedge clk) disable iff (rst)
    !trn |=> (ph == PH_W'($past(ph) + PH_W'(1))));

  assert_rdata_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(rdata) |-> $fell(rclk));

  assert_step_bound_R5: assert property (@(posedge clk) disable iff (rst)
    trn |=> (PH_W'(ph - $past(ph) - PH_W'(1) + PH_W'(BIG_STEP)) <= PH_W'(2 * BIG_STEP)));

  assert_small_step_R6: assert property (@(posedge clk) disable iff (rst)
    (trn && !fast_en) |=> (PH_W'(ph - $past(ph)) <= PH_W'(2)));

  assert_lock_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !trn |=> $stable(locked));
endmodule

bind bitclk_dpll dpll_chk #(.PH_W(PH_W), .BIG_STEP(BIG_STEP)) u_chk (
  .clk(clk), .rst(rst), .fast_en(fast_en), .rclk(rclk), .rdata(rdata),
  .locked(locked), .trn(trn), .ph(ph)
);

// File: tb/sim_bitclk_dpll.sv
module sim_bitclk_dpll;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic fast_en = 1'b1;
  logic slow_acq = 1'b0;
  logic rclk, rdata, locked;

  int total = 0;
  int bad = 0;
  bit done = 0;

  bitclk_dpll u0 (
    .clk(clk), .rst(rst), .din(din), .fast_en(fast_en), .slow_acq(slow_acq),
    .rclk(rclk), .rdata(rdata), .locked(locked)
  );

  always #2 clk = ~clk;

  // behavioural reference model
  int m_d1, m_d2, m_ph, m_rdata, m_lock, m_good, m_bad;
  initial begin
    m_d1 = 0; m_d2 = 0; m_ph = 0; m_rdata = 0; m_lock = 0; m_good = 0; m_bad = 0;
  end

  always @(posedge clk) begin
    int e, mag, st, base, nph;
    if (rst) begin
      m_d1 = 0; m_d2 = 0; m_ph = 0; m_rdata = 0; m_lock = 0; m_good = 0; m_bad = 0;
    end else begin
      nph = (m_ph + 1) % 64;
      if (m_d1 != m_d2) begin
        e = (m_ph < 32) ? m_ph : m_ph - 64;
        mag = (e < 0) ? -e : e;
        base = (fast_en && mag > 4) ? (slow_acq ? 1 : 4) : 1;
        st = (mag < base) ? mag : base;
        if (e > 0) nph = (m_ph + 1 - st + 64) % 64;
        else if (e < 0) nph = (m_ph + 1 + st) % 64;
        if (mag <= 1) begin
          m_bad = 0; m_good = (m_good < 8) ? m_good + 1 : 8;
          if (m_good == 8) m_lock = 1;
        end else if (mag > 4) begin
          m_good = 0; m_bad = (m_bad < 4) ? m_bad + 1 : 4;
          if (m_bad == 4) m_lock = 0;
        end else begin
          m_good = 0; m_bad = 0;
        end
      end
      if (m_ph < 32 && nph >= 32) m_rdata = m_d1;
      m_ph = nph;
      m_d2 = m_d1;
      m_d1 = int'(din);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (!done) begin
      chk(int'(rclk) == int'(m_ph < 32), "R2 rclk", int'(rclk), int'(m_ph < 32));
      chk(int'(rdata) == m_rdata, "R3 rdata", int'(rdata), m_rdata);
      chk(int'(locked) == m_lock, "R7 locked", int'(locked), m_lock);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic alt_bits(input int n);
    for (int i = 0; i < n; i++) begin
      din = ~din;
      wait_cyc(64);
    end
  endtask

  int unsigned rs = 32'h1234_5677;
  task automatic rand_bits(input int n);
    for (int i = 0; i < n; i++) begin
      rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
      din = rs[0];
      wait_cyc(64);
    end
  endtask

  task automatic do_reset;
    rst = 1'b1;
    wait_cyc(3);
    chk(rclk == 1'b1 && rdata == 1'b0 && locked == 1'b0, "R1 reset state",
        int'({rclk, rdata, locked}), 4);
    rst = 1'b0;
  endtask

  initial begin
    int falls;
    // fast acquisition from half a bit off
    fast_en = 1'b1; slow_acq = 1'b0; din = 1'b0;
    do_reset();
    wait_cyc(29);
    alt_bits(18);
    chk(locked == 1'b1, "R8 fast lock within 18 bits", int'(locked), 1);
    chk(locked == 1'b1, "R5 large step used while far", int'(locked), 1);

    // no transitions: lock and clock unchanged
    falls = 0;
    for (int i = 0; i < 640; i++) begin
      @(negedge clk);
      if (u0.rclk == 1'b0 && m_ph == 32) falls++;
    end
    chk(falls == 10, "R10 free run falls in 10 bits", falls, 10);
    chk(locked == 1'b1, "R10 lock kept without transitions", int'(locked), 1);

    // half-bit phase jump: 3 far transitions keep lock, the 4th drops it
    wait_cyc(32);
    alt_bits(3);
    chk(locked == 1'b1, "R7 lock held after 3 far", int'(locked), 1);
    alt_bits(1);
    chk(locked == 1'b0, "R7 lock dropped after 4 far", int'(locked), 0);
    alt_bits(20);
    chk(locked == 1'b1, "R6 relock through small steps", int'(locked), 1);

    // fast correction disabled: small steps only
    fast_en = 1'b0;
    do_reset();
    wait_cyc(29);
    alt_bits(18);
    chk(locked == 1'b0, "R8 no lock in 18 bits with fast_en=0", int'(locked), 0);
    alt_bits(32);
    chk(locked == 1'b1, "R6 small-step loop locks eventually", int'(locked), 1);

    // slow acquisition
    fast_en = 1'b1; slow_acq = 1'b1;
    do_reset();
    wait_cyc(29);
    alt_bits(20);
    chk(locked == 1'b0, "R9 slow not locked at 20 bits", int'(locked), 0);
    alt_bits(30);
    chk(locked == 1'b1, "R9 slow lock within 50 bits", int'(locked), 1);

    // random data at a new phase, then near offset with fast step
    slow_acq = 1'b0;
    wait_cyc(9);
    rand_bits(60);
    chk(bad == 0, "R4 random data tracked against model", bad, 0);
    do_reset();
    wait_cyc(5);
    alt_bits(12);
    chk(locked == 1'b1, "R6 near offset locks", int'(locked), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule